// File: doc/BRIEF.md
# Serial Register Access Slave

This block is the control-port end of a radio front end. A baseband master reaches a bank of 16-bit configuration registers over a three-wire serial link: a serial clock, one data line and a latch strobe that is held low while a frame is in flight. A frame is 25 bits long and is sent most significant bit first. It carries a device address, a direction flag, a register address and a data word. The slave accepts only frames whose device address matches its own. A write takes effect when the strobe rises. For a read, the slave takes over the data line and shifts the register contents back to the master.

All serial inputs are sampled by the block's own clock through synchronizers. Serial edges therefore become single-cycle events inside one clock domain. The data line is presented as three signals: input, output and output enable. The pad ring joins these into the single bidirectional pin. One register address is wired to a read-only status word supplied from outside, such as a received signal strength value. Every other address is plain storage, and all storage is visible in parallel to the radio logic.

Top module: `serial_reg_slave`

## Requirements
- R1: A frame is sampled from `sd_i` on falling edges of `ser_clk` while `ser_latch` is low, MSB first, in this order: bits 24..22 are the device address, bit 21 is the direction (1 = read, 0 = write), bits 20..16 are the register address and bits 15..0 are data d15..d0.
- R2: While `ser_latch` is high, the bit position is held at zero, so `ser_clk` activity between frames has no effect and the next frame starts at its first bit.
- R3: When `ser_latch` rises after a complete write frame with device address 101, the 16 data bits appear in the addressed slot of `cfg_regs` (register k at bits k*16+15..k*16) within 4 `clk` cycles.
- R4: A frame whose device address is not 101 changes no register, and `sd_oe` stays low for the whole frame.
- R5: If `ser_latch` rises before all 25 bits have arrived, the frame is discarded and the following frame is decoded from its first bit.
- R6: Falling edges after the 25th bit of a frame are ignored, so the write commits the data carried in bits 15..0.
- R7: In a matching read frame, `sd_oe` rises after the `ser_clk` rising edge that follows the 9th bit. `sd_o` then shows d15 and advances one bit on each later rising edge, so that all 16 data bits are valid during the high phases of bits 9..24.
- R8: `sd_oe` is low during the header of every frame, throughout write frames, after the 25th falling edge, and again within 3 cycles of `ser_latch` rising, including when a read is cut short.
- R9: Register address 31 reads back `status_in` as it stands at the first data rising edge. Writes to address 31 change nothing, and its slot in `cfg_regs` reads 0.
- R10: After reset, every slot of `cfg_regs` is 0 and `sd_oe` is low.
- R11: A read frame leaves the register it reads unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to sample the serial link |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the master |
| ser_latch | input | 1 | Frame strobe: low while a frame is in flight, rising edge commits a write |
| sd_i | input | 1 | Data from the pad (master to slave) |
| sd_o | output | 1 | Read data towards the pad |
| sd_oe | output | 1 | Pad output enable for read data |
| status_in | input | 16 | Read-only status word returned at address 31 |
| cfg_regs | output | 512 | All register slots in parallel, register k at bits k*16+15..k*16 |

## Verification
The bench aims at the frame-alignment corners. A strobe that rises early must throw the partial frame away: a slave that does not clear its bit count would misread the next frame's device address and either drop that frame or write to the wrong slot. Clock pulses while the strobe is idle and trailing bits after the 25th must both be harmless. A design that counted them would shift the data word, or commit the trailing ones. Reads are checked bit by bit across all 16 data phases, which exposes a driver that turns on during the header or one that returns the word one bit late. The status address is written and then read with a changed input, which separates a true read-only path from one that stores the value.

// File: rtl/srs_pkg.sv
package srs_pkg;

    localparam int DEV_W   = 3;
    localparam int ADR_W   = 5;
    localparam int DAT_W   = 16;
    localparam int HDR_W   = DEV_W + 1 + ADR_W;
    localparam int FRAME_W = HDR_W + DAT_W;
    localparam int CNT_W   = $clog2((DAT_W > HDR_W) ? DAT_W : HDR_W);

    localparam logic [DEV_W-1:0] PHY_DEV_ID = 3'b101;

    typedef logic [DAT_W-1:0] word_t;
    typedef logic [ADR_W-1:0] radr_t;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic             rd;
        radr_t            adr;
    } hdr_t;

    typedef struct packed {
        logic  valid;
        radr_t adr;
        word_t data;
    } wr_req_t;

    typedef enum logic [1:0] {
        S_HDR  = 2'd0,
        S_DATA = 2'd1,
        S_FULL = 2'd2
    } frame_st_t;

    function automatic word_t shift_up(input word_t w);
        return {w[DAT_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[s] <= RST_VAL;
            end else if (s == 0) begin
                chain[s] <= d;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s - 1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/srs_frame_ctl.sv
module srs_frame_ctl
    import srs_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ID = PHY_DEV_ID
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk_rise,
    input  logic    sclk_fall,
    input  logic    lat_lvl,
    input  logic    lat_rise,
    input  logic    sd_in,
    input  word_t   rd_word,
    output hdr_t    hdr_q,
    output wr_req_t wr_req,
    output logic    sd_o,
    output logic    sd_oe
);

    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DAT_W - 1);

    frame_st_t        state;
    logic [CNT_W-1:0] cnt;
    logic [HDR_W-1:0] hdr_sr;
    word_t            dat_sr;
    word_t            shadow;
    logic             rd_go;

    hdr_t  hdr_nxt;
    word_t dat_nxt;
    word_t src;

    assign hdr_nxt = hdr_t'({hdr_sr[HDR_W-2:0], sd_in});
    assign dat_nxt = {dat_sr[DAT_W-2:0], sd_in};
    assign src     = sd_oe ? shadow : rd_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_HDR;
            cnt    <= '0;
            hdr_sr <= '0;
            hdr_q  <= '0;
            dat_sr <= '0;
            shadow <= '0;
            rd_go  <= 1'b0;
            sd_o   <= 1'b0;
            sd_oe  <= 1'b0;
            wr_req <= '0;
        end else begin
            wr_req.valid <= lat_rise && (state == S_FULL) &&
                            (hdr_q.dev == DEV_ID) && !hdr_q.rd;
            wr_req.adr   <= hdr_q.adr;
            wr_req.data  <= dat_sr;

            if (lat_lvl) begin
                state <= S_HDR;
                cnt   <= '0;
                rd_go <= 1'b0;
                sd_oe <= 1'b0;
            end else if (sclk_fall) begin
                case (state)
                    S_HDR: begin
                        hdr_sr <= hdr_nxt;
                        if (cnt == HDR_LAST) begin
                            hdr_q <= hdr_nxt;
                            rd_go <= (hdr_nxt.dev == DEV_ID) && hdr_nxt.rd;
                            cnt   <= '0;
                            state <= S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        dat_sr <= dat_nxt;
                        if (cnt == DAT_LAST) begin
                            cnt   <= '0;
                            sd_oe <= 1'b0;
                            state <= S_FULL;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end else if (sclk_rise && (state == S_DATA) && rd_go) begin
                sd_o   <= src[DAT_W-1];
                shadow <= shift_up(src);
                sd_oe  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/srs_reg_bank.sv
module srs_reg_bank
    import srs_pkg::*;
#(
    parameter int NUM_REGS   = 32,
    parameter int STATUS_ADR = 31
) (
    input  logic                      clk,
    input  logic                      rst,
    input  wr_req_t                   wr_req,
    input  radr_t                     rd_adr,
    input  word_t                     status_in,
    output word_t                     rd_word,
    output logic [NUM_REGS*DAT_W-1:0] cfg_regs
);

    word_t slot [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i == STATUS_ADR) begin : g_ro
            assign slot[i] = '0;
        end else begin : g_rw
            word_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else if (wr_req.valid && (wr_req.adr == radr_t'(i))) begin
                    q <= wr_req.data;
                end
            end
            assign slot[i] = q;
        end
        assign cfg_regs[i*DAT_W +: DAT_W] = slot[i];
    end

    always_comb begin
        if (int'(rd_adr) == STATUS_ADR) begin
            rd_word = status_in;
        end else if (int'(rd_adr) < NUM_REGS) begin
            rd_word = slot[rd_adr];
        end else begin
            rd_word = '0;
        end
    end

endmodule

// File: rtl/serial_reg_slave.sv
module serial_reg_slave
    import srs_pkg::*;
#(
    parameter int               NUM_REGS    = 32,
    parameter int               STATUS_ADR  = 31,
    parameter int               SYNC_STAGES = 2,
    parameter logic [DEV_W-1:0] DEV_ID      = PHY_DEV_ID
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ser_clk,
    input  logic                      ser_latch,
    input  logic                      sd_i,
    output logic                      sd_o,
    output logic                      sd_oe,
    input  logic [DAT_W-1:0]          status_in,
    output logic [NUM_REGS*DAT_W-1:0] cfg_regs
);

    logic [2:0] pins_q;
    logic       sclk_lvl, lat_lvl, sd_lvl;
    logic       sclk_prev, lat_prev;
    logic       sclk_rise, sclk_fall, lat_rise;
    hdr_t       hdr_q;
    wr_req_t    wr_req;
    word_t      rd_word;

    srs_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_clk, ser_latch, sd_i}),
        .q   (pins_q)
    );

    assign {sclk_lvl, lat_lvl, sd_lvl} = pins_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
            lat_prev  <= 1'b1;
        end else begin
            sclk_prev <= sclk_lvl;
            lat_prev  <= lat_lvl;
        end
    end

    assign sclk_rise = sclk_lvl & ~sclk_prev;
    assign sclk_fall = ~sclk_lvl & sclk_prev;
    assign lat_rise  = lat_lvl & ~lat_prev;

    srs_frame_ctl #(
        .DEV_ID (DEV_ID)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .lat_lvl   (lat_lvl),
        .lat_rise  (lat_rise),
        .sd_in     (sd_lvl),
        .rd_word   (rd_word),
        .hdr_q     (hdr_q),
        .wr_req    (wr_req),
        .sd_o      (sd_o),
        .sd_oe     (sd_oe)
    );

    srs_reg_bank #(
        .NUM_REGS   (NUM_REGS),
        .STATUS_ADR (STATUS_ADR)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_req),
        .rd_adr    (hdr_q.adr),
        .status_in (status_in),
        .rd_word   (rd_word),
        .cfg_regs  (cfg_regs)
    );

endmodule

// File: rtl/srs_checker.sv
module srs_checker
    import srs_pkg::*;
#(
    parameter int               NUM_REGS   = 32,
    parameter int               STATUS_ADR = 31,
    parameter logic [DEV_W-1:0] DEV_ID     = PHY_DEV_ID
) (
    input logic                      clk,
    input logic                      rst,
    input wr_req_t                   wr_req,
    input logic [NUM_REGS*DAT_W-1:0] cfg_regs,
    input logic                      sd_oe,
    input logic                      lat_lvl,
    input logic                      sclk_rise,
    input hdr_t                      hdr_q
);

    radr_t last_adr;
    word_t last_data;
    logic  last_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_adr  <= '0;
            last_data <= '0;
            last_ok   <= 1'b0;
        end else begin
            last_adr  <= wr_req.adr;
            last_data <= wr_req.data;
            last_ok   <= wr_req.valid && (int'(wr_req.adr) != STATUS_ADR) &&
                         (int'(wr_req.adr) < NUM_REGS);
        end
    end

    // R3: a commit request lands in its slot one cycle later
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        last_ok |-> (cfg_regs[int'(last_adr)*DAT_W +: DAT_W] == last_data));

    // R3: commit request is a single-cycle pulse
    p_wr_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        wr_req.valid |=> !wr_req.valid);

    // R4: registers move only after a commit request
    p_regs_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_regs) |-> $past(wr_req.valid));

    // R4: driver only for a matching read header
    p_oe_match_r4: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> ((hdr_q.dev == DEV_ID) && hdr_q.rd));

    // R7: driver turns on only just after a serial rising edge
    p_oe_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_oe) |-> $past(sclk_rise));

    // R8: driver never on while the strobe was high
    p_oe_latch_r8: assert property (@(posedge clk) disable iff (rst)
        sd_oe |-> $past(!lat_lvl));

    // R9: writes to the status address leave all storage alone
    p_status_ro_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_req.valid && (int'(wr_req.adr) == STATUS_ADR)) |=> $stable(cfg_regs));

endmodule

bind serial_reg_slave srs_checker #(
    .NUM_REGS   (NUM_REGS),
    .STATUS_ADR (STATUS_ADR),
    .DEV_ID     (DEV_ID)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_req    (wr_req),
    .cfg_regs  (cfg_regs),
    .sd_oe     (sd_oe),
    .lat_lvl   (lat_lvl),
    .sclk_rise (sclk_rise),
    .hdr_q     (hdr_q)
);

// File: tb/serial_reg_slave_bench.sv
module serial_reg_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NREG       = 32;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ser_clk = 1'b0;
    logic              ser_latch = 1'b1;
    logic              sd_i = 1'b0;
    logic              sd_o;
    logic              sd_oe;
    logic [15:0]       status_in = 16'h0000;
    logic [NREG*16-1:0] cfg_regs;

    int total = 0;
    int bad   = 0;
    int oe_cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (sd_oe) oe_cycles++;

    serial_reg_slave u_serial_reg_slave (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_latch (ser_latch),
        .sd_i      (sd_i),
        .sd_o      (sd_o),
        .sd_oe     (sd_oe),
        .status_in (status_in),
        .cfg_regs  (cfg_regs)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] slot(input int k);
        return cfg_regs[k*16 +: 16];
    endfunction

    task automatic run_frame(input logic [2:0] dev, input logic rd, input logic [4:0] adr,
                             input logic [15:0] data, input int nbits,
                             output logic [15:0] got, output int oe_hdr, output int oe_data);
        logic [24:0] v;
        v = {dev, rd, adr, data};
        got = '0;
        oe_hdr = 0;
        oe_data = 0;
        ser_latch = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            ser_clk = 1'b1;
            sd_i = (i < 25) ? v[24-i] : 1'b1;
            wait_clk(HALF);
            if (sd_oe) begin
                if (i >= 9 && i < 25) oe_data++;
                else oe_hdr++;
            end
            if (i >= 9 && i < 25) got[24-i] = sd_o;
            ser_clk = 1'b0;
            wait_clk(HALF);
        end
        ser_latch = 1'b1;
        wait_clk(2*HALF);
    endtask

    task automatic wr(input logic [2:0] dev, input logic [4:0] adr, input logic [15:0] data, input int nbits);
        logic [15:0] g;
        int h, d;
        run_frame(dev, 1'b0, adr, data, nbits, g, h, d);
    endtask

    task automatic rd_chk(input logic [4:0] adr, input logic [15:0] exp, input string tag);
        logic [15:0] g;
        int h, d;
        run_frame(3'b101, 1'b1, adr, 16'h0000, 25, g, h, d);
        chk(g == exp, tag, {16'h0, g}, {16'h0, exp});
        chk(h == 0 && d == 16, "R7 oe window", h*100 + d, 16);
    endtask

    task automatic t_reset();
        logic ok;
        ok = (cfg_regs == '0);
        chk(ok, "R10 regs zero", {31'h0, !ok}, 0);
        chk(sd_oe == 1'b0, "R10 oe low", {31'h0, sd_oe}, 0);
    endtask

    task automatic t_write_read();
        oe_cycles = 0;
        wr(3'b101, 5'd3, 16'hA5C3, 25);
        chk(slot(3) == 16'hA5C3, "R3 write lands", {16'h0, slot(3)}, 32'hA5C3);
        chk(oe_cycles == 0, "R8 no drive in write", oe_cycles, 0);
        rd_chk(5'd3, 16'hA5C3, "R7 read back");
        chk(slot(3) == 16'hA5C3, "R11 read keeps reg", {16'h0, slot(3)}, 32'hA5C3);
    endtask

    task automatic t_patterns();
        wr(3'b101, 5'd0, 16'hFFFF, 25);
        wr(3'b101, 5'd17, 16'h0001, 25);
        wr(3'b101, 5'd30, 16'h8000, 25);
        chk(slot(0) == 16'hFFFF, "R1 all ones", {16'h0, slot(0)}, 32'hFFFF);
        chk(slot(17) == 16'h0001, "R1 lsb only", {16'h0, slot(17)}, 32'h0001);
        chk(slot(30) == 16'h8000, "R1 msb only", {16'h0, slot(30)}, 32'h8000);
        rd_chk(5'd17, 16'h0001, "R1 read lsb");
        rd_chk(5'd30, 16'h8000, "R1 read msb");
    endtask

    task automatic t_bad_dev();
        logic [15:0] g;
        int h, d;
        wr(3'b100, 5'd3, 16'h1111, 25);
        chk(slot(3) == 16'hA5C3, "R4 wrong dev write", {16'h0, slot(3)}, 32'hA5C3);
        oe_cycles = 0;
        run_frame(3'b011, 1'b1, 5'd3, 16'h0000, 25, g, h, d);
        chk(oe_cycles == 0, "R4 wrong dev read no drive", oe_cycles, 0);
    endtask

    task automatic t_short();
        wr(3'b101, 5'd5, 16'hDEAD, 20);
        chk(slot(5) == 16'h0000, "R5 short discarded", {16'h0, slot(5)}, 0);
        wr(3'b101, 5'd5, 16'h1234, 25);
        chk(slot(5) == 16'h1234, "R5 next frame aligned", {16'h0, slot(5)}, 32'h1234);
    endtask

    task automatic t_long();
        wr(3'b101, 5'd6, 16'h1200, 30);
        chk(slot(6) == 16'h1200, "R6 trailing bits ignored", {16'h0, slot(6)}, 32'h1200);
    endtask

    task automatic t_idle_clocks();
        for (int i = 0; i < 10; i++) begin
            ser_clk = 1'b1;
            sd_i = 1'b1;
            wait_clk(HALF);
            ser_clk = 1'b0;
            wait_clk(HALF);
        end
        wr(3'b101, 5'd9, 16'h0F0F, 25);
        chk(slot(9) == 16'h0F0F, "R2 idle clocks ignored", {16'h0, slot(9)}, 32'h0F0F);
    endtask

    task automatic t_status();
        status_in = 16'h5A5A;
        rd_chk(5'd31, 16'h5A5A, "R9 status read");
        wr(3'b101, 5'd31, 16'hFFFF, 25);
        chk(slot(31) == 16'h0000, "R9 status slot zero", {16'h0, slot(31)}, 0);
        status_in = 16'h0F0E;
        rd_chk(5'd31, 16'h0F0E, "R9 status not stored");
    endtask

    task automatic t_abort_read();
        logic [15:0] g;
        int h, d;
        run_frame(3'b101, 1'b1, 5'd3, 16'h0000, 12, g, h, d);
        chk(d == 3, "R7 partial read drove", d, 3);
        chk(sd_oe == 1'b0, "R8 abort releases", {31'h0, sd_oe}, 0);
        chk(slot(3) == 16'hA5C3, "R11 aborted read keeps reg", {16'h0, slot(3)}, 32'hA5C3);
    endtask

    initial begin
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        t_reset();
        t_write_read();
        t_patterns();
        t_bad_dev();
        t_short();
        t_long();
        t_idle_clocks();
        t_status();
        t_abort_read();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=finished", WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule